// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block is a small power management unit that owns two switchable compute domains and a whole-chip deep sleep state. Software reaches it through a register port that uses valid/ready handshakes. A control register holds one "keep up" request per domain and a deep sleep request. The unit walks each domain through a timed power-down or power-up phase and reports in a status register which domains are live and whether deep sleep is active. Each domain has a power-management enable, and a domain refuses to power down until its enable is set. Each domain also has a clock source select that moves it from the always-on clock to its fast PLL clock. That select reaches the domain only while the domain is up.

Deep sleep can be entered only after both domains are down. A deep sleep request that arrives while either domain is live stays pending. Once deep sleep status has been seen, software clears the request bit, and deep sleep persists. Setting any domain request bit leaves deep sleep before that domain starts its power-up.

The register port accepts a request when `req_valid` and `req_ready` are both high. Exactly one response follows, one cycle later, on `rsp_valid`. `req_ready` is low while a response is held with `rsp_ready` low, so a stalled response back-pressures the request side. During the stall the response data does not change.

Top module: `pds_power_ctrl`

## Requirements
- R1: After reset, the control word (address 0) reads 3'b011, the status word (address 1) reads 3'b011, the option words (addresses 2 and 3) read 0, the clock select words (addresses 4 and 5) read 0, and `pll_sel` is 0.
- R2: Each accepted request yields one response on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` holds its value. A write returns 0 as its response data.
- R3: Domain i can power down only while bit 29 of its option word (address 2+i) is set. When control bit i is cleared under that condition, status bit i and `pwr_up[i]` fall exactly DN_LAT+1 cycles after the accepting clock edge.
- R4: While bit 29 of a domain's option word is 0, clearing that domain's control bit has no effect, and its status bit stays 1.
- R5: Setting control bit i for a domain that is down raises status bit i exactly UP_LAT+1 cycles after the accepting edge.
- R6: When one write changes both domain request bits, each status bit settles on its own latency. The combined change is complete once both bits equal their requests.
- R7: Control bit 2 requests deep sleep. Status bit 2 rises only when both domains are down. With both bits 1:0 cleared in the same write as bit 2, it rises DN_LAT+DS_LAT+2 cycles after the accepting edge. While it is set, status bits 2:0 read 3'b100.
- R8: Clearing control bit 2 while deep sleep is active leaves deep sleep active.
- R9: Setting a domain request bit while deep sleep is active clears status bit 2 one cycle after the accepting edge. The domain then comes up UP_LAT+2 cycles after that edge.
- R10: `pll_sel[i]` is 1 exactly when bit 0 of the clock select word for domain i (address 4+i) is 1 and domain i is up.
- R11: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted when high with req_valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| pwr_up | output | 2 | Live up flag per domain |
| ds_active | output | 1 | Deep sleep active |
| pll_sel | output | 2 | Per-domain clock mux select to PLL clock |

## Verification
The hardest case to reach from the ports is leaving deep sleep. First, enable power management on both domains. Then send a single write that clears both domain requests and sets the deep sleep request. After the domain and deep sleep latencies have run out, clear the deep sleep request, and only then set a domain bit. The bench measures, cycle by cycle, when deep sleep clears and when the domain comes up, and compares both against the latencies. Before that, a sweep covers every start and target pairing of the two domain request bits and checks each settle time arithmetically.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int NDOM     = 2;
  localparam int DATA_W   = 32;
  localparam int PM_EN_BIT = 29;
  localparam int CTRL_DS_BIT = NDOM;

  typedef enum logic [1:0] {DOM_ON, DOM_FALL, DOM_OFF, DOM_RISE} dom_state_t;
  typedef enum logic [1:0] {DS_IDLE, DS_ENTER, DS_ACTIVE} ds_state_t;
endpackage

// File: rtl/pds_domain_seq.sv
module pds_domain_seq
  import pds_pkg::*;
#(
  parameter int UP_LAT = 16,
  parameter int DN_LAT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_req,
  input  logic pm_en,
  input  logic hold,
  output logic is_up,
  output logic is_off
);
  localparam int MAXLAT = (UP_LAT > DN_LAT) ? UP_LAT : DN_LAT;
  localparam int CW = (MAXLAT > 1) ? $clog2(MAXLAT) : 1;

  dom_state_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= DOM_ON;
      cnt <= '0;
    end else begin
      unique case (st)
        DOM_ON: if (!up_req && pm_en) begin
          st  <= DOM_FALL;
          cnt <= CW'(DN_LAT - 1);
        end
        DOM_FALL: if (cnt == '0) st <= DOM_OFF;
                  else cnt <= cnt - 1'b1;
        DOM_OFF: if (up_req && !hold) begin
          st  <= DOM_RISE;
          cnt <= CW'(UP_LAT - 1);
        end
        DOM_RISE: if (cnt == '0) st <= DOM_ON;
                  else cnt <= cnt - 1'b1;
        default: st <= DOM_ON;
      endcase
    end
  end

  // Up until the power-down phase finishes; down until power-up finishes.
  assign is_up  = (st == DOM_ON) || (st == DOM_FALL);
  assign is_off = (st == DOM_OFF);
endmodule

// File: rtl/pds_deep_sleep.sv
module pds_deep_sleep
  import pds_pkg::*;
#(
  parameter int DS_LAT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ds_req,
  input  logic any_up_req,
  input  logic all_off,
  output logic active,
  output logic busy
);
  localparam int CW = (DS_LAT > 1) ? $clog2(DS_LAT) : 1;

  ds_state_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= DS_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        DS_IDLE: if (ds_req && all_off && !any_up_req) begin
          st  <= DS_ENTER;
          cnt <= CW'(DS_LAT - 1);
        end
        DS_ENTER: begin
          if (!ds_req || any_up_req) st <= DS_IDLE;
          else if (cnt == '0)        st <= DS_ACTIVE;
          else                       cnt <= cnt - 1'b1;
        end
        DS_ACTIVE: if (any_up_req) st <= DS_IDLE;
        default: st <= DS_IDLE;
      endcase
    end
  end

  assign active = (st == DS_ACTIVE);
  assign busy   = (st != DS_IDLE);
endmodule

// File: rtl/pds_reg_port.sv
module pds_reg_port
  import pds_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [NDOM:0]     status,
  output logic [NDOM-1:0]   ctrl_up,
  output logic              ctrl_ds,
  output logic [NDOM-1:0]   pm_en,
  output logic [NDOM-1:0]   clk_sel
);
  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_OPT  = 2;
  localparam int A_SEL  = A_OPT + NDOM;

  logic accept;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    rd_mux = '0;
    if (int'(req_addr) == A_CTRL) rd_mux[NDOM:0] = {ctrl_ds, ctrl_up};
    if (int'(req_addr) == A_STAT) rd_mux[NDOM:0] = status;
    for (int i = 0; i < NDOM; i++) begin
      if (int'(req_addr) == A_OPT + i) rd_mux[PM_EN_BIT] = pm_en[i];
      if (int'(req_addr) == A_SEL + i) rd_mux[0] = clk_sel[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_up <= '1;
      ctrl_ds <= 1'b0;
    end else if (accept && req_write && int'(req_addr) == A_CTRL) begin
      ctrl_up <= req_wdata[NDOM-1:0];
      ctrl_ds <= req_wdata[CTRL_DS_BIT];
    end
  end

  for (genvar g = 0; g < NDOM; g++) begin : g_dom_regs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pm_en[g]   <= 1'b0;
        clk_sel[g] <= 1'b0;
      end else if (accept && req_write) begin
        if (int'(req_addr) == A_OPT + g) pm_en[g]   <= req_wdata[PM_EN_BIT];
        if (int'(req_addr) == A_SEL + g) clk_sel[g] <= req_wdata[0];
      end
    end
  end
endmodule

// File: rtl/pds_power_ctrl.sv
module pds_power_ctrl
  import pds_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int UP_LAT = 16,
  parameter int DN_LAT = 16,
  parameter int DS_LAT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [1:0]        pwr_up,
  output logic              ds_active,
  output logic [1:0]        pll_sel
);
  logic [NDOM-1:0] ctrl_up, pm_en, clk_sel, dom_off;
  logic ctrl_ds, ds_busy;

  pds_reg_port #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .status({ds_active, pwr_up}),
    .ctrl_up(ctrl_up), .ctrl_ds(ctrl_ds), .pm_en(pm_en), .clk_sel(clk_sel)
  );

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    pds_domain_seq #(.UP_LAT(UP_LAT), .DN_LAT(DN_LAT)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .up_req(ctrl_up[g]), .pm_en(pm_en[g]), .hold(ds_busy),
      .is_up(pwr_up[g]), .is_off(dom_off[g])
    );
  end

  pds_deep_sleep #(.DS_LAT(DS_LAT)) u_ds (
    .clk(clk), .rst_n(rst_n),
    .ds_req(ctrl_ds), .any_up_req(|ctrl_up), .all_off(&dom_off),
    .active(ds_active), .busy(ds_busy)
  );

  assign pll_sel = clk_sel & pwr_up;
endmodule

// File: rtl/pds_power_ctrl_chk.sv
module pds_power_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic [1:0]  pwr_up,
  input logic        ds_active,
  input logic [1:0]  pll_sel,
  input logic [1:0]  ctrl_up
);
  assert_stall_blocks_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_rsp_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_ds_all_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ds_active |-> (pwr_up == 2'b00));

  assert_ds_entry_from_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_active) |-> ($past(pwr_up) == 2'b00));

  assert_ds_exit_on_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_active && ctrl_up != 2'b00) |=> !ds_active);

  assert_pll_needs_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_sel & ~pwr_up) == 2'b00);
endmodule

bind pds_power_ctrl pds_power_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .pwr_up(pwr_up),
  .ds_active(ds_active), .pll_sel(pll_sel), .ctrl_up(ctrl_up)
);

// File: tb/pds_power_ctrl_test.sv
module pds_power_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int UP = 3;
  localparam int DN = 5;
  localparam int DS = 4;
  localparam logic [31:0] PM = 32'h2000_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [2:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, ds_active;
  logic [31:0] rsp_rdata;
  logic [1:0] pwr_up, pll_sel;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pds_power_ctrl #(.ADDR_W(3), .UP_LAT(UP), .DN_LAT(DN), .DS_LAT(DS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pwr_up(pwr_up), .ds_active(ds_active), .pll_sel(pll_sel));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 3'(a); req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 3'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Cycles after the accepting edge until signal vector reaches target (0 if already there).
  task automatic settle(input logic [1:0] tgt, output int t0, output int t1);
    t0 = (pwr_up[0] == tgt[0]) ? 0 : -1;
    t1 = (pwr_up[1] == tgt[1]) ? 0 : -1;
    for (int n = 1; n <= 30; n++) begin
      @(posedge clk); @(negedge clk);
      if (t0 < 0 && pwr_up[0] == tgt[0]) t0 = n;
      if (t1 < 0 && pwr_up[1] == tgt[1]) t1 = n;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, held;
    int t0, t1, n;
    idle(3);
    rst_n = 1;
    idle(2);

    // R1 reset values
    rd(0, d); check("R1 ctrl", int'(d), 3);
    rd(1, d); check("R1 status", int'(d), 3);
    rd(2, d); check("R1 optA", int'(d), 0);
    rd(3, d); check("R1 optB", int'(d), 0);
    rd(4, d); check("R1 selA", int'(d), 0);
    rd(5, d); check("R1 selB", int'(d), 0);
    check("R1 pll_sel", int'(pll_sel), 0);

    // R4 down ignored while enable is 0
    wr(0, 32'h0);
    idle(20);
    check("R4 pwr_up", int'(pwr_up), 3);
    rd(1, d); check("R4 status", int'(d), 3);

    // R11 unmapped addresses
    wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
    rd(6, d); check("R11 rd6", int'(d), 0);
    rd(7, d); check("R11 rd7", int'(d), 0);
    rd(0, d); check("R11 ctrl kept", int'(d), 0);
    rd(2, d); check("R11 opt kept", int'(d), 0);
    wr(0, 32'h3);

    // enable power management on both
    wr(2, PM); wr(3, PM);
    rd(2, d); check("R3 optA bit29", int'(d[29]), 1);
    idle(5);

    // R3 R5 R6 sweep all start/target pairs
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        logic [1:0] fv, tv;
        fv = 2'(f); tv = 2'(t);
        wr(0, 32'(fv));
        idle(20);
        check("R6 start", int'(pwr_up), f);
        wr(0, 32'(tv));
        settle(tv, t0, t1);
        check(tv[0] ? "R5 domA" : "R3 domA", t0,
              (fv[0] == tv[0]) ? 0 : (tv[0] ? UP + 1 : DN + 1));
        check(tv[1] ? "R5 domB" : "R3 domB", t1,
              (fv[1] == tv[1]) ? 0 : (tv[1] ? UP + 1 : DN + 1));
        rd(1, d); check("R6 final", int'(d), t);
      end
    end

    // R10 clock select follows up state
    wr(0, 32'h3); idle(20);
    wr(4, 32'h1);
    check("R10 sel on up", int'(pll_sel), 1);
    wr(0, 32'h2); idle(20);
    check("R10 sel when down", int'(pll_sel), 0);
    rd(4, d); check("R10 reg kept", int'(d), 1);
    wr(0, 32'h3); idle(20);
    check("R10 sel back", int'(pll_sel), 1);
    wr(4, 32'h0);
    check("R10 sel cleared", int'(pll_sel), 0);

    // R7 deep sleep entry with domains going down together
    wr(0, 32'h4);
    n = -1;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == DN + 1) check("R7 pending", int'(ds_active), 0);
      if (n < 0 && ds_active) n = k;
    end
    check("R7 entry time", n, DN + DS + 2);
    rd(1, d); check("R7 status 100", int'(d), 4);

    // R8 clearing request keeps deep sleep
    wr(0, 32'h0); idle(15);
    check("R8 ds kept", int'(ds_active), 1);
    rd(1, d); check("R8 status", int'(d), 4);

    // R9 domain up request exits deep sleep first
    wr(0, 32'h1);
    check("R9 ds before edge", int'(ds_active), 1);
    n = -1; t0 = -1;
    for (int k = 1; k <= 30; k++) begin
      @(posedge clk); @(negedge clk);
      if (n < 0 && !ds_active) n = k;
      if (t0 < 0 && pwr_up[0]) t0 = k;
    end
    check("R9 exit time", n, 1);
    check("R9 up time", t0, UP + 2);
    check("R9 B stays down", int'(pwr_up[1]), 0);

    // R7 request while domain A up stays pending
    wr(0, 32'h4);
    wr(2, 32'h0);
    wr(0, 32'h5);
    idle(30);
    check("R7 held pending", int'(ds_active), 0);
    wr(0, 32'h4);
    idle(30);
    check("R7 A enable 0 keeps A", int'(pwr_up), 1);
    check("R7 still pending", int'(ds_active), 0);

    // R2 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 3'd1;
    @(posedge clk); @(negedge clk);
    held = rsp_rdata;
    req_addr = 3'd0;
    check("R2 rsp valid", int'(rsp_valid), 1);
    check("R2 first data", int'(held), 1);
    for (int k = 0; k < 3; k++) begin
      check("R2 ready low", int'(req_ready), 0);
      @(posedge clk); @(negedge clk);
      check("R2 data held", int'(rsp_rdata), int'(held));
    end
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check("R2 second rsp", int'(rsp_valid), 1);
    check("R2 second data", int'(rsp_rdata), 4);
    wr(0, 32'h3);
    check("R2 write rsp zero", int'(rsp_rdata), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule